// File: doc/BRIEF.md
# Processor Flag Register with Single-Bit Set and Clear

This block holds the eight status flags of a small processor core: global interrupt enable, a user transfer bit, half carry, sign, overflow, negative, zero and carry. The execution unit hands it fresh flag values together with one update enable per flag, and only the enabled arithmetic flags change. An instruction can also set or clear any one bit by its index in a single cycle, with no read-modify-write sequence, so no other bit can be disturbed while it happens. The whole byte can be loaded through an I/O write port, and the current byte is always visible on the output.

The sign flag is not an independent state bit. It always shows the exclusive OR of the negative and overflow flags, however those two reached their values. When several sources write in the same clock cycle, an I/O byte write wins over a bit operation, and a bit operation wins over an arithmetic flag update. The losing source is dropped completely for that cycle.

Top module: `status_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the status output is 8'h00, so interrupts are disabled.
- R2: With no I/O write and no bit operation, each arithmetic flag (C bit 0, Z bit 1, N bit 2, V bit 3, H bit 5) whose enable is high takes its input value on the next edge. Each flag whose enable is low keeps its value.
- R3: Update enables at bits 4, 6 and 7 have no effect. I and T keep their values through any arithmetic flag update.
- R4: A bit operation with set selected and index s (0 to 7) sets bit s on the next edge and leaves every other stored bit unchanged. Index 7 enables interrupts.
- R5: A bit operation with clear selected and index s clears only bit s on the next edge.
- R6: Output bit 4 always equals bit 2 XOR bit 3. This holds after arithmetic updates, bit operations and byte writes. A write or bit operation aimed at bit 4 alone does not change the output.
- R7: An I/O write loads the written byte into bits 7, 6, 5, 3, 2, 1 and 0 on the next edge.
- R8: When an I/O write and a bit operation happen in the same cycle, only the I/O byte takes effect.
- R9: When a bit operation and an arithmetic flag update happen in the same cycle, only the bit operation takes effect.
- R10: With no I/O write, no bit operation and no arithmetic enable high, the output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_val | input | 8 | New flag values from the execution unit, in status bit positions |
| alu_en | input | 8 | Per-flag update enables, in status bit positions |
| bit_op_valid | input | 1 | Strobe for a single-bit set or clear |
| bit_op_set | input | 1 | 1 sets the indexed bit, 0 clears it |
| bit_op_idx | input | 3 | Index of the bit that the bit operation targets |
| io_we | input | 1 | I/O byte write strobe |
| io_wdata | input | 8 | I/O byte write data |
| status | output | 8 | Current status byte, with bit 4 derived |

## Verification
Three sources can fall in the same cycle. The collisions of interest are an I/O byte write arriving with a bit operation, and a bit operation arriving with an arithmetic update that has every enable high. The bench drives each pair in one cycle, using values for which the losing source would leave a visible trace. It then reads the byte one edge later. The result counts as correct only if it matches the winner's effect alone: the written byte in the first case, and a single changed bit in the second.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   // Fixed flag positions; the sign derivation and the execution unit rely on them.
   localparam int unsigned POS_C = 0;
   localparam int unsigned POS_Z = 1;
   localparam int unsigned POS_N = 2;
   localparam int unsigned POS_V = 3;
   localparam int unsigned POS_S = 4;
   localparam int unsigned POS_H = 5;
   localparam int unsigned POS_T = 6;
   localparam int unsigned POS_I = 7;

   // Which source wrote the register in a given cycle.
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_ALU  = 2'd1,
      SRC_BIT  = 2'd2,
      SRC_IO   = 2'd3
   } sreg_src_e;

endpackage

// File: rtl/sreg_bit_dec.sv
module sreg_bit_dec #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned IDX_W = $clog2(REG_W)
) (
   input  logic             sel_valid,
   input  logic [IDX_W-1:0] sel_idx,
   output logic [REG_W-1:0] sel_mask
);

   // One-hot mask for the targeted bit; all zero when no operation is pending.
   for (genvar g = 0; g < REG_W; g++) begin : g_bit
      assign sel_mask[g] = sel_valid && (sel_idx == IDX_W'(g));
   end

   // R4: a pending bit operation selects exactly one bit.
   always_comb begin
      if (sel_valid) begin
         a_r4_one_bit: assert ($onehot(sel_mask));
      end
   end

endmodule

// File: rtl/sreg_next.sv
module sreg_next
   import sreg_pkg::*;
#(
   parameter int unsigned      REG_W    = 8,
   parameter logic [REG_W-1:0] ALU_MASK = 8'h2F
) (
   input  logic [REG_W-1:0] cur,
   input  logic [REG_W-1:0] alu_val,
   input  logic [REG_W-1:0] alu_en,
   input  logic             bop_valid,
   input  logic             bop_set,
   input  logic [REG_W-1:0] bop_mask,
   input  logic             io_we,
   input  logic [REG_W-1:0] io_wdata,
   output logic [REG_W-1:0] nxt,
   output sreg_src_e        src
);

   logic [REG_W-1:0] upd;
   assign upd = alu_en & ALU_MASK;

   // One winner per cycle: byte write, then bit operation, then flag update.
   always_comb begin
      nxt = cur;
      src = SRC_NONE;
      if (io_we) begin
         nxt = io_wdata;
         src = SRC_IO;
      end else if (bop_valid) begin
         nxt = bop_set ? (cur | bop_mask) : (cur & ~bop_mask);
         src = SRC_BIT;
      end else if (|upd) begin
         nxt = (cur & ~upd) | (alu_val & upd);
         src = SRC_ALU;
      end
   end

   // R8: a byte write always owns the cycle.
   always_comb begin
      if (io_we) begin
         a_r8_io_wins: assert (src == SRC_IO);
      end
   end

endmodule

// File: rtl/sreg_sign.sv
module sreg_sign #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned SIGN_POS = 4,
   parameter int unsigned NEG_POS  = 2,
   parameter int unsigned OVF_POS  = 3
) (
   input  logic [REG_W-1:0] flags_in,
   output logic [REG_W-1:0] flags_out
);

   always_comb begin
      flags_out           = flags_in;
      flags_out[SIGN_POS] = flags_in[NEG_POS] ^ flags_in[OVF_POS];
   end

endmodule

// File: rtl/status_reg.sv
module status_reg
   import sreg_pkg::*;
#(
   parameter int unsigned      REG_W       = 8,
   parameter logic [REG_W-1:0] ALU_MASK    = 8'h2F,
   parameter bit               DERIVE_SIGN = 1'b1,
   localparam int unsigned     IDX_W       = $clog2(REG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] alu_val,
   input  logic [REG_W-1:0] alu_en,
   input  logic             bit_op_valid,
   input  logic             bit_op_set,
   input  logic [IDX_W-1:0] bit_op_idx,
   input  logic             io_we,
   input  logic [REG_W-1:0] io_wdata,
   output logic [REG_W-1:0] status
);

   localparam logic [REG_W-1:0] SMASK = REG_W'(1) << POS_S;

   // Elaboration-time parameter checks.
   if (REG_W < 8) begin : g_chk_width
      $error("status_reg: REG_W must hold all eight flags");
   end
   if (ALU_MASK[POS_S] || ALU_MASK[POS_I] || ALU_MASK[POS_T]) begin : g_chk_mask
      $error("status_reg: ALU_MASK must not cover S, T or I");
   end

   logic [REG_W-1:0] q;
   logic [REG_W-1:0] d_raw;
   logic [REG_W-1:0] d;
   logic [REG_W-1:0] bop_mask;
   sreg_src_e        src;

   sreg_bit_dec #(.REG_W(REG_W), .IDX_W(IDX_W)) u_dec (
      .sel_valid (bit_op_valid),
      .sel_idx   (bit_op_idx),
      .sel_mask  (bop_mask)
   );

   sreg_next #(.REG_W(REG_W), .ALU_MASK(ALU_MASK)) u_next (
      .cur       (q),
      .alu_val   (alu_val),
      .alu_en    (alu_en),
      .bop_valid (bit_op_valid),
      .bop_set   (bit_op_set),
      .bop_mask  (bop_mask),
      .io_we     (io_we),
      .io_wdata  (io_wdata),
      .nxt       (d_raw),
      .src       (src)
   );

   // Sign either derived after the flop or folded into the stored value.
   if (DERIVE_SIGN) begin : g_sign_derived
      assign d = d_raw;
      sreg_sign #(.REG_W(REG_W), .SIGN_POS(POS_S), .NEG_POS(POS_N), .OVF_POS(POS_V)) u_sign (
         .flags_in  (q),
         .flags_out (status)
      );
   end else begin : g_sign_stored
      sreg_sign #(.REG_W(REG_W), .SIGN_POS(POS_S), .NEG_POS(POS_N), .OVF_POS(POS_V)) u_sign (
         .flags_in  (d_raw),
         .flags_out (d)
      );
      assign status = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

   // ---------------- assertions ----------------

   // R1: cleared while in reset.
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_clear: assert (status == '0);
      end
   end

   // R6: output sign follows N and V from the stored flags.
   a_r6_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
      status[POS_S] == (status[POS_N] ^ status[POS_V]));

   // R7: byte write lands on the next edge.
   a_r7_io_load: assert property (@(posedge clk) disable iff (!rst_n)
      io_we |=> (((status ^ $past(io_wdata)) & ~SMASK) == '0));

   // R4: set reaches the indexed bit.
   a_r4_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_we && bit_op_valid && bit_op_set && bit_op_idx != IDX_W'(POS_S))
      |=> status[$past(bit_op_idx)]);

   // R5: clear reaches the indexed bit.
   a_r5_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_we && bit_op_valid && !bit_op_set && bit_op_idx != IDX_W'(POS_S))
      |=> !status[$past(bit_op_idx)]);

   // R9: bit operation touches no other stored bit, even with ALU enables high.
   a_r9_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_we && bit_op_valid)
      |=> (((status ^ $past(status)) & ~(REG_W'(1) << $past(bit_op_idx)) & ~SMASK) == '0));

   // R3: bits outside the ALU mask survive any arithmetic update.
   a_r3_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_we && !bit_op_valid)
      |=> (((status ^ $past(status)) & ~ALU_MASK & ~SMASK) == '0));

   // R10: nothing pending, nothing changes.
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_we && !bit_op_valid && ((alu_en & ALU_MASK) == '0)) |=> $stable(status));

   // R2: source tag reports an arithmetic update only when an enabled flag exists.
   a_r2_alu_src: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_ALU) |-> ((alu_en & ALU_MASK) != '0));

endmodule

// File: tb/status_reg_bench.sv
`timescale 1ns/1ps
module status_reg_bench;

   localparam logic [7:0] AMASK = 8'h2F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [7:0] alu_val = '0;
   logic [7:0] alu_en = '0;
   logic       bit_op_valid = 1'b0;
   logic       bit_op_set = 1'b0;
   logic [2:0] bit_op_idx = '0;
   logic       io_we = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;
   logic [7:0] m = '0;   // stored-bit model

   always #2.5 clk = ~clk;

   status_reg u_status_reg (
      .clk, .rst_n, .alu_val, .alu_en, .bit_op_valid, .bit_op_set,
      .bit_op_idx, .io_we, .io_wdata, .status
   );

   function automatic logic [7:0] view(input logic [7:0] s);
      logic [7:0] r;
      r = s;
      r[4] = s[2] ^ s[3];
      return r;
   endfunction

   task automatic check(input string req, input logic [7:0] exp);
      checks++;
      if (status !== exp) begin
         errors++;
         $display("FAIL %s: status=%h expected %h", req, status, exp);
      end
   endtask

   task automatic idle_inputs();
      alu_val = '0; alu_en = '0; bit_op_valid = 1'b0; bit_op_set = 1'b0;
      bit_op_idx = '0; io_we = 1'b0; io_wdata = '0;
   endtask

   // Inputs are set at a falling edge; advance through one rising edge.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 in reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      m = '0;
      check("R1 after release", 8'h00);
   endtask

   task automatic t_alu();
      alu_val = 8'hFF; alu_en = 8'hFF; step();
      m = (m & ~AMASK) | (8'hFF & AMASK);
      check("R2 all enables", view(m));
      alu_val = 8'h00; alu_en = 8'h05; step();   // clear C and N only
      m = (m & ~8'h05);
      check("R2 partial enables", view(m));
      alu_val = 8'hFF; alu_en = 8'hD0; step();   // only S/T/I enables
      check("R3 ignored enables", view(m));
   endtask

   task automatic t_bitop();
      for (int i = 0; i < 8; i++) begin
         bit_op_valid = 1'b1; bit_op_set = 1'b1; bit_op_idx = 3'(i); step();
         m[i] = 1'b1;
         check($sformatf("R4 set idx %0d", i), view(m));
      end
      for (int i = 7; i >= 0; i--) begin
         bit_op_valid = 1'b1; bit_op_set = 1'b0; bit_op_idx = 3'(i); step();
         m[i] = 1'b0;
         check($sformatf("R5 clear idx %0d", i), view(m));
      end
   endtask

   task automatic t_sign();
      io_we = 1'b1; io_wdata = 8'h08; step();
      m = 8'h08;
      check("R6 V only gives S", 8'h18);
      bit_op_valid = 1'b1; bit_op_set = 1'b1; bit_op_idx = 3'd2; step();
      m[2] = 1'b1;
      check("R6 N and V cancel", 8'h0C);
      io_we = 1'b1; io_wdata = 8'h10; step();
      m = 8'h10;
      check("R6 write to S alone", 8'h00);
      bit_op_valid = 1'b1; bit_op_set = 1'b1; bit_op_idx = 3'd4; step();
      m[4] = 1'b1;
      check("R6 set S alone", 8'h00);
      alu_val = 8'h04; alu_en = 8'h04; step();
      m[2] = 1'b1;
      check("R6 ALU sets N", view(m));
   endtask

   task automatic t_io();
      io_we = 1'b1; io_wdata = 8'hA5; step();
      m = 8'hA5;
      check("R7 byte write", 8'hB5);
      io_we = 1'b1; io_wdata = 8'h42; step();
      m = 8'h42;
      check("R7 second byte", view(m));
   endtask

   task automatic t_io_vs_bit();
      io_we = 1'b1; io_wdata = 8'h00;
      bit_op_valid = 1'b1; bit_op_set = 1'b1; bit_op_idx = 3'd7; step();
      m = 8'h00;
      check("R8 io beats bit set", 8'h00);
      io_we = 1'b1; io_wdata = 8'hFF;
      bit_op_valid = 1'b1; bit_op_set = 1'b0; bit_op_idx = 3'd0; step();
      m = 8'hFF;
      check("R8 io beats bit clear", view(m));
   endtask

   task automatic t_bit_vs_alu();
      io_we = 1'b1; io_wdata = 8'h00; step();
      m = 8'h00;
      bit_op_valid = 1'b1; bit_op_set = 1'b1; bit_op_idx = 3'd6;
      alu_val = 8'hFF; alu_en = 8'hFF; step();
      m[6] = 1'b1;
      check("R9 bit set beats ALU", 8'h40);
      bit_op_valid = 1'b1; bit_op_set = 1'b0; bit_op_idx = 3'd6;
      alu_val = 8'hFF; alu_en = 8'h01; step();
      m[6] = 1'b0;
      check("R9 bit clear beats ALU", 8'h00);
   endtask

   task automatic t_idle();
      io_we = 1'b1; io_wdata = 8'hC9; step();
      m = 8'hC9;
      alu_val = 8'hFF; alu_en = 8'h00; step();
      step();
      check("R10 hold when idle", view(m));
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_alu();
      t_bitop();
      t_sign();
      t_io();
      t_io_vs_bit();
      t_bit_vs_alu();
      t_idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule